// File: doc/BRIEF.md
# Audio Codec Clock-Enable Divider Tree

This block turns one master clock into the sampling-rate strobes of an audio codec. There are two cascades. The playback cascade is a root divider, then a modulator divider, then an oversampling divider. The record cascade has the same three stages. Every stage produces a one-cycle clock-enable pulse in the master clock domain. The next stage counts those pulses, so the whole tree runs from a single clock.

A small gating controller sits between the configuration words and the counters. It starts a root divider before its child. When a divider is switched off, the controller waits until the downstream channel reports that it is powered down. It then stops the child before the root. When both record dividers are off, the record oversampling stage takes its input from the playback modulator strobe. This change of source happens only while the record oversampling counter holds no partial count.

There is no data stream through the block. All pins are plain control, status or strobe signals, so no valid/ready back-pressure applies.

Top module: `codec_clk_tree`

## Requirements
- R1: Each root and modulator divider is controlled by an 8-bit word: bit 7 requests the divider and bits 6:0 hold the divide value N. The output strobe repeats every N of its input strobes, and N=0 means 128. The modulator strobe period is the root value times the modulator value, in master clock cycles.
- R2: The playback oversampling value is 10 bits wide, given as a 2-bit upper part and an 8-bit lower part. The value 0 means 1024. The playback sample strobe comes once every that many playback modulator strobes.
- R3: The record oversampling value is 8 bits wide, and 0 means 256. The record sample strobe comes once every that many record modulator strobes.
- R4: A requested root divider runs from the first clock edge after its request. A modulator divider starts only at the edge after its root is running. A modulator divider never runs while its root is stopped.
- R5: A playback divider whose request is withdrawn keeps running while either playback power flag is high. Once both flags are low, the modulator divider stops at the next edge and the root divider stops at the edge after that.
- R6: A record divider whose request is withdrawn keeps running while the record power flag is high. Once the flag is low, the record modulator divider stops first and the record root divider stops at the following edge.
- R7: When both record dividers are stopped, rec_on_pb goes high and the record modulator strobe becomes the playback modulator strobe.
- R8: While rec_on_pb is high and the record power flag is high, the playback root divider keeps running even if its request is withdrawn.
- R9: While rec_on_pb is high and rec_rate_req is high, the playback modulator divider keeps running even if its request is withdrawn and the playback flags are low.
- R10: rec_on_pb changes only while the record oversampling counter holds no partial count. Every record sample strobe therefore spans exactly the record oversampling value of record modulator strobes.
- R11: div_running reports the actual run state of each divider: bit 0 playback root, bit 1 playback modulator, bit 2 record root, bit 3 record modulator.
- R12: After reset all dividers are stopped, no strobe is produced and rec_on_pb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_root_cfg | input | 8 | Playback root divider: request bit 7, value bits 6:0 |
| pb_mod_cfg | input | 8 | Playback modulator divider: request bit 7, value bits 6:0 |
| pb_osr_hi | input | 2 | Playback oversampling value, upper bits |
| pb_osr_lo | input | 8 | Playback oversampling value, lower bits |
| rec_root_cfg | input | 8 | Record root divider: request bit 7, value bits 6:0 |
| rec_mod_cfg | input | 8 | Record modulator divider: request bit 7, value bits 6:0 |
| rec_osr | input | 8 | Record oversampling value |
| pb_busy | input | 2 | Playback power flags, high while still powered |
| rec_busy | input | 1 | Record power flag, high while still powered |
| rec_rate_req | input | 1 | Record sample rate is needed |
| pb_mod_ce | output | 1 | Playback modulator strobe |
| pb_fs_ce | output | 1 | Playback sample strobe |
| rec_mod_ce | output | 1 | Record modulator strobe |
| rec_fs_ce | output | 1 | Record sample strobe |
| rec_on_pb | output | 1 | Record oversampling stage is fed from the playback chain |
| div_running | output | 4 | Actual run state of the four dividers |

## Verification
The hardest case to reach from the pins is a change of record clock source while the record oversampling counter is part way through a group. The bench runs the record chain with a small oversampling value. It then withdraws the record dividers at an arbitrary point and later brings the playback chain back under the record side. A monitor counts record modulator strobes between record sample strobes. It restarts its count only when div_running shows that the selected source has stopped, so any sample strobe built from a short group is reported. The hold cases are reached by withdrawing playback requests while the record power flag or rec_rate_req is held high with rec_on_pb set, and then dropping those signals one at a time.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned STAGE_W    = 7;
  localparam int unsigned PB_OSR_W   = 10;
  localparam int unsigned REC_OSR_W  = 8;
  localparam int unsigned N_GATED    = 4;

  typedef struct packed {
    logic               req;
    logic [STAGE_W-1:0] value;
  } div_word_t;

  typedef enum logic [1:0] {
    IDX_PB_ROOT  = 2'd0,
    IDX_PB_MOD   = 2'd1,
    IDX_REC_ROOT = 2'd2,
    IDX_REC_MOD  = 2'd3
  } div_idx_e;
endpackage

// File: rtl/codec_clk_stage.sv
module codec_clk_stage #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         ce_i,
  input  logic [W-1:0] value_i,
  output logic         pulse_o,
  output logic         zero_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  // a value of zero wraps to all ones, which gives the full 2**W count
  assign last    = value_i - 1'b1;
  assign pulse_o = run_i & ce_i & (cnt == last);
  assign zero_o  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (ce_i)       cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  a_r1_wrap_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> zero_o);
endmodule

// File: rtl/codec_clk_gate.sv
module codec_clk_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_pb_root,
  input  logic       req_pb_mod,
  input  logic       req_rec_root,
  input  logic       req_rec_mod,
  input  logic [1:0] pb_busy,
  input  logic       rec_busy,
  input  logic       rec_rate_req,
  input  logic       rec_on_pb,
  output logic       run_pb_root,
  output logic       run_pb_mod,
  output logic       run_rec_root,
  output logic       run_rec_mod
);
  logic pb_idle;
  logic keep_pb_root;
  logic keep_pb_mod;

  assign pb_idle      = ~|pb_busy;
  assign keep_pb_root = rec_on_pb & rec_busy;
  assign keep_pb_mod  = rec_on_pb & rec_rate_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_pb_root  <= 1'b0;
      run_pb_mod   <= 1'b0;
      run_rec_root <= 1'b0;
      run_rec_mod  <= 1'b0;
    end else begin
      // playback root: stops only after its child, when playback is down
      if (req_pb_root)
        run_pb_root <= 1'b1;
      else if (pb_idle && !run_pb_mod && !keep_pb_root)
        run_pb_root <= 1'b0;

      if (req_pb_mod && run_pb_root)
        run_pb_mod <= 1'b1;
      else if (!req_pb_mod && pb_idle && !keep_pb_mod)
        run_pb_mod <= 1'b0;

      if (req_rec_root)
        run_rec_root <= 1'b1;
      else if (!rec_busy && !run_rec_mod)
        run_rec_root <= 1'b0;

      if (req_rec_mod && run_rec_root)
        run_rec_mod <= 1'b1;
      else if (!req_rec_mod && !rec_busy)
        run_rec_mod <= 1'b0;
    end
  end

  a_r4_pb_child_needs_root: assert property (@(posedge clk) disable iff (!rst_n)
    run_pb_mod |-> run_pb_root);
  a_r4_rec_child_needs_root: assert property (@(posedge clk) disable iff (!rst_n)
    run_rec_mod |-> run_rec_root);
  a_r5_pb_mod_stops_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_pb_mod) |-> $past(pb_idle));
  a_r6_rec_mod_stops_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_rec_mod) |-> $past(!rec_busy));
  a_r8_pb_root_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_pb_root) |-> $past(!(rec_on_pb && rec_busy)));
endmodule

// File: rtl/codec_clk_tree.sv
module codec_clk_tree
  import codec_clk_pkg::*;
#(
  parameter int unsigned STG_W  = STAGE_W,
  parameter int unsigned POSR_W = PB_OSR_W,
  parameter int unsigned ROSR_W = REC_OSR_W,
  localparam int unsigned HI_W  = POSR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STG_W:0]    pb_root_cfg,
  input  logic [STG_W:0]    pb_mod_cfg,
  input  logic [HI_W-1:0]   pb_osr_hi,
  input  logic [7:0]        pb_osr_lo,
  input  logic [STG_W:0]    rec_root_cfg,
  input  logic [STG_W:0]    rec_mod_cfg,
  input  logic [ROSR_W-1:0] rec_osr,
  input  logic [1:0]        pb_busy,
  input  logic              rec_busy,
  input  logic              rec_rate_req,
  output logic              pb_mod_ce,
  output logic              pb_fs_ce,
  output logic              rec_mod_ce,
  output logic              rec_fs_ce,
  output logic              rec_on_pb,
  output logic [3:0]        div_running
);
  logic [STG_W:0] cfg_word [4];
  logic [3:0]     stage_ce;
  logic [3:0]     stage_pulse;
  logic [3:0]     stage_zero;
  logic           pb_osr_zero;
  logic           rec_osr_zero;
  logic           rec_osr_run;
  logic           rec_own_mod;

  assign cfg_word[IDX_PB_ROOT]  = pb_root_cfg;
  assign cfg_word[IDX_PB_MOD]   = pb_mod_cfg;
  assign cfg_word[IDX_REC_ROOT] = rec_root_cfg;
  assign cfg_word[IDX_REC_MOD]  = rec_mod_cfg;

  codec_clk_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_pb_root  (pb_root_cfg[STG_W]),
    .req_pb_mod   (pb_mod_cfg[STG_W]),
    .req_rec_root (rec_root_cfg[STG_W]),
    .req_rec_mod  (rec_mod_cfg[STG_W]),
    .pb_busy      (pb_busy),
    .rec_busy     (rec_busy),
    .rec_rate_req (rec_rate_req),
    .rec_on_pb    (rec_on_pb),
    .run_pb_root  (div_running[IDX_PB_ROOT]),
    .run_pb_mod   (div_running[IDX_PB_MOD]),
    .run_rec_root (div_running[IDX_REC_ROOT]),
    .run_rec_mod  (div_running[IDX_REC_MOD])
  );

  // roots count master cycles, modulators count their root's strobes
  assign stage_ce = {stage_pulse[IDX_REC_ROOT], 1'b1, stage_pulse[IDX_PB_ROOT], 1'b1};

  for (genvar g = 0; g < 4; g++) begin : g_stage
    codec_clk_stage #(.W(STG_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (div_running[g]),
      .ce_i    (stage_ce[g]),
      .value_i (cfg_word[g][STG_W-1:0]),
      .pulse_o (stage_pulse[g]),
      .zero_o  (stage_zero[g])
    );
  end

  assign pb_mod_ce   = stage_pulse[IDX_PB_MOD];
  assign rec_own_mod = stage_pulse[IDX_REC_MOD];

  codec_clk_stage #(.W(POSR_W)) u_pb_osr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (div_running[IDX_PB_MOD]),
    .ce_i    (pb_mod_ce),
    .value_i ({pb_osr_hi, pb_osr_lo}),
    .pulse_o (pb_fs_ce),
    .zero_o  (pb_osr_zero)
  );

  assign rec_osr_run = rec_on_pb ? div_running[IDX_PB_MOD] : div_running[IDX_REC_MOD];
  assign rec_mod_ce  = rec_on_pb ? pb_mod_ce : rec_own_mod;

  codec_clk_stage #(.W(ROSR_W)) u_rec_osr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (rec_osr_run),
    .ce_i    (rec_mod_ce),
    .value_i (rec_osr),
    .pulse_o (rec_fs_ce),
    .zero_o  (rec_osr_zero)
  );

  // source changes only on an empty oversampling count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_on_pb <= 1'b1;
    else if (rec_osr_zero) rec_on_pb <= ~(div_running[IDX_REC_ROOT] | div_running[IDX_REC_MOD]);
  end

  a_r10_switch_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_on_pb) |-> $past(rec_osr_zero));
  a_r12_stopped_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_running) == 4'b0000) |-> (&{stage_zero, pb_osr_zero}));
endmodule

// File: tb/codec_clk_tree_tb.sv
`timescale 1ns/1ps
module codec_clk_tree_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pb_root_cfg = '0, pb_mod_cfg = '0, rec_root_cfg = '0, rec_mod_cfg = '0;
  logic [1:0] pb_osr_hi = '0;
  logic [7:0] pb_osr_lo = 8'd4;
  logic [7:0] rec_osr = 8'd3;
  logic [1:0] pb_busy = '0;
  logic       rec_busy = 1'b0, rec_rate_req = 1'b0;
  logic       pb_mod_ce, pb_fs_ce, rec_mod_ce, rec_fs_ce, rec_on_pb;
  logic [3:0] div_running;

  int checks = 0, errors = 0;
  int mon_cnt = 0, mon_bad = 0, mon_groups = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_clk_tree u_dut (
    .clk(clk), .rst_n(rst_n),
    .pb_root_cfg(pb_root_cfg), .pb_mod_cfg(pb_mod_cfg),
    .pb_osr_hi(pb_osr_hi), .pb_osr_lo(pb_osr_lo),
    .rec_root_cfg(rec_root_cfg), .rec_mod_cfg(rec_mod_cfg), .rec_osr(rec_osr),
    .pb_busy(pb_busy), .rec_busy(rec_busy), .rec_rate_req(rec_rate_req),
    .pb_mod_ce(pb_mod_ce), .pb_fs_ce(pb_fs_ce), .rec_mod_ce(rec_mod_ce),
    .rec_fs_ce(rec_fs_ce), .rec_on_pb(rec_on_pb), .div_running(div_running)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10 monitor: every record sample strobe spans rec_osr modulator strobes
  logic prev_sel = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((rec_on_pb != prev_sel) || !(rec_on_pb ? div_running[1] : div_running[3]))
        mon_cnt = 0;
      if (rec_mod_ce) mon_cnt++;
      if (rec_fs_ce) begin
        mon_groups++;
        if (mon_cnt != int'(rec_osr)) mon_bad++;
        mon_cnt = 0;
      end
      prev_sel = rec_on_pb;
    end
  end

  function automatic logic strobe(input int sel);
    case (sel)
      0: return pb_mod_ce;
      1: return pb_fs_ce;
      2: return rec_mod_ce;
      default: return rec_fs_ce;
    endcase
  endfunction

  task automatic period(input int sel, output int cyc);
    int n = 0;
    cyc = -1;
    while (!strobe(sel) && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    n = 1;
    while (!strobe(sel) && n < 5000) begin @(negedge clk); n++; end
    if (strobe(sel)) cyc = n;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 running after reset", int'(div_running), 0);
    chk("R12 playback strobe after reset", int'(pb_mod_ce | pb_fs_ce), 0);
    chk("R12 rec_on_pb after reset", int'(rec_on_pb), 1);
  endtask

  task automatic t_pb_start;
    int p;
    pb_busy = 2'b11;
    pb_root_cfg = {1'b1, 7'd3};
    pb_mod_cfg  = {1'b1, 7'd2};
    @(negedge clk);
    chk("R4 root first", int'(div_running[1:0]), 1);
    @(negedge clk);
    chk("R4 child next", int'(div_running[1:0]), 3);
    chk("R11 status bits", int'(div_running), 3);
    period(0, p); chk("R1 playback modulator period 3x2", p, 6);
    period(1, p); chk("R2 playback sample period 6x4", p, 24);
  endtask

  task automatic t_zero_values;
    int p;
    pb_root_cfg = {1'b1, 7'd1};
    pb_mod_cfg  = {1'b1, 7'd0};
    period(0, p); period(0, p);
    chk("R1 zero value is 128", p, 128);
    pb_mod_cfg = {1'b1, 7'd1};
    pb_osr_lo = 8'd0;
    period(1, p); period(1, p);
    chk("R2 zero value is 1024", p, 1024);
    pb_root_cfg = {1'b1, 7'd3};
    pb_mod_cfg  = {1'b1, 7'd2};
    pb_osr_lo = 8'd4;
    idle(30);
  endtask

  task automatic t_rec_own;
    int p;
    int n = 0;
    rec_busy = 1'b1;
    rec_root_cfg = {1'b1, 7'd2};
    rec_mod_cfg  = {1'b1, 7'd5};
    while (rec_on_pb && n < 200) begin @(negedge clk); n++; end
    chk("R7 own record chain selected", int'(rec_on_pb), 0);
    chk("R11 record bits", int'(div_running[3:2]), 3);
    period(2, p); chk("R1 record modulator period 2x5", p, 10);
    period(3, p); chk("R3 record sample period 10x3", p, 30);
  endtask

  task automatic t_rec_defer;
    int p;
    int n = 0;
    idle(7);
    rec_root_cfg[7] = 1'b0;
    rec_mod_cfg[7]  = 1'b0;
    idle(20);
    chk("R6 record held while flag high", int'(div_running[3:2]), 3);
    rec_busy = 1'b0;
    @(negedge clk);
    chk("R6 record modulator stops first", int'(div_running[3:2]), 1);
    @(negedge clk);
    chk("R6 record root stops next", int'(div_running[3:2]), 0);
    while (!rec_on_pb && n < 200) begin @(negedge clk); n++; end
    chk("R7 fallback to playback", int'(rec_on_pb), 1);
    period(2, p); chk("R7 record strobe follows playback", p, 6);
  endtask

  task automatic t_pb_defer;
    pb_busy = 2'b11;
    pb_root_cfg[7] = 1'b0;
    pb_mod_cfg[7]  = 1'b0;
    idle(10);
    chk("R5 playback held, both flags high", int'(div_running[1:0]), 3);
    pb_busy = 2'b01;
    idle(10);
    chk("R5 playback held, one flag high", int'(div_running[1:0]), 3);
    pb_busy = 2'b00;
    @(negedge clk);
    chk("R5 modulator stops first", int'(div_running[1:0]), 1);
    @(negedge clk);
    chk("R5 root stops after child", int'(div_running[1:0]), 0);
  endtask

  task automatic t_rec_holds;
    pb_root_cfg[7] = 1'b1;
    pb_mod_cfg[7]  = 1'b1;
    idle(5);
    rec_busy = 1'b1;
    rec_rate_req = 1'b1;
    idle(3);
    pb_root_cfg[7] = 1'b0;
    pb_mod_cfg[7]  = 1'b0;
    idle(10);
    chk("R9 playback modulator held for record rate", int'(div_running[1:0]), 3);
    rec_rate_req = 1'b0;
    @(negedge clk);
    chk("R9 modulator released", int'(div_running[1:0]), 1);
    idle(10);
    chk("R8 playback root held for record", int'(div_running[1:0]), 1);
    rec_busy = 1'b0;
    @(negedge clk);
    chk("R8 root released", int'(div_running[1:0]), 0);
  endtask

  task automatic t_child_gate;
    pb_mod_cfg[7] = 1'b1;
    idle(10);
    chk("R4 child waits for root", int'(div_running[1:0]), 0);
    pb_root_cfg[7] = 1'b1;
    @(negedge clk);
    chk("R4 root starts", int'(div_running[1:0]), 1);
    @(negedge clk);
    chk("R4 child follows", int'(div_running[1:0]), 3);
    idle(100);
    chk("R10 no short record sample group", mon_bad, 0);
    chk("R10 record groups observed", int'(mon_groups > 3), 1);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pb_start();
    t_zero_values();
    t_rec_own();
    t_rec_defer();
    t_pb_defer();
    t_rec_holds();
    t_child_gate();
    done = 1;
    report();
  end
endmodule